// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Unit

This block gathers the interrupt-worthy events of a network controller into one 16-bit status register. Next to it sits a 16-bit mask register that software can read and write. Each event source delivers a single-cycle pulse, and the pulse sets its own status bit. The status bit is set whether or not the matching mask bit is enabled. A single registered, active-low interrupt line is driven while any pending status bit also has its mask bit set.

Software reaches the block over a simple synchronous register bus made of an address, a read strobe, a write strobe, write data and combinational read data. Reading the status word returns the bits pending before the read and then clears all of them in one step. Writing to the status word does nothing.

A free-running cycle counter is compared against a programmable threshold register, and a match raises the timeout event. The underrun/link bit has two triggers: a link state change, or a write to the receive read pointer while the receive buffer is empty.

Top module: `net_irq_ctrl`

## Requirements
- R1: Reset (asynchronous, active low) clears the mask, the status register and the cycle counter, and drives irq_no high.
- R2: Address 0 selects the mask, 1 the status, 2 the timer threshold and 3 the cycle counter. The mask reads back the value written, except that bits 12 to 7 always read 0.
- R3: A pulse sets its status bit on the next edge whether the mask bit is set or not. The bit map is: 15 bus error, 14 timeout, 13 cable length change, 6 receive status FIFO overflow, 5 underrun/link change, 4 receive ring overflow, 3 transmit error, 2 transmit OK, 1 receive error, 0 receive OK. Bits 12 to 7 stay 0.
- R4: irq_no is low in the cycle after the edge on which some status bit and its mask bit are both 1. It stays high while every pending bit is masked off.
- R5: A status read returns the pending bits in the read cycle and clears them all on that cycle's edge. irq_no is high in the next cycle.
- R6: An event that arrives in the same cycle as a status read stays pending after the clear. That read does not report it.
- R7: A write to the status address leaves the status bits unchanged.
- R8: Bit 5 is set by a link change pulse, or by a receive-pointer write while rx_empty_i is 1. A receive-pointer write while rx_empty_i is 0 does not set it.
- R9: The cycle counter increments on every edge and reads back at address 3. Any write to address 3 restarts it at 0 on that edge.
- R10: Timeout bit 14 is set when the counter equals a non-zero threshold. A threshold of 0 never sets it.
- R11: Enabling a mask bit while its status bit is already pending pulls irq_no low in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while rd_i is high |
| ev_bus_err_i | input | 1 | Bus error pulse |
| ev_len_chg_i | input | 1 | Cable length change pulse |
| ev_rx_fifo_ovf_i | input | 1 | Receive status FIFO overflow pulse |
| ev_link_chg_i | input | 1 | Link state change pulse |
| rx_ptr_wr_i | input | 1 | Receive read pointer written |
| rx_empty_i | input | 1 | Receive buffer empty level |
| ev_rx_ring_ovf_i | input | 1 | Receive ring overflow pulse |
| ev_tx_err_i | input | 1 | Transmit abort pulse |
| ev_tx_ok_i | input | 1 | Transmit done pulse |
| ev_rx_err_i | input | 1 | Receive CRC or alignment error pulse |
| ev_rx_ok_i | input | 1 | Receive done pulse |
| irq_no | output | 1 | Interrupt, registered, active low |

## Verification
Any wrong status or mask flop shows up on irq_no one cycle after the edge that corrupted it. It also shows up in the read data of the next status or mask read. A clear that fires too early, too late, or a second time is caught by the read after it: that read returns a stale bit or drops an event that arrived together with the clear. A miscounting timer appears as a wrong counter value two edges apart, or as a missing or spurious bit 14.

// File: rtl/net_irq_pkg.sv
package net_irq_pkg;

  localparam int unsigned IRQ_W = 16;
  // implemented bits: 15..13 and 6..0
  localparam logic [IRQ_W-1:0] IRQ_IMPL = 16'hE07F;

  localparam int unsigned B_RX_OK       = 0;
  localparam int unsigned B_RX_ERR      = 1;
  localparam int unsigned B_TX_OK       = 2;
  localparam int unsigned B_TX_ERR      = 3;
  localparam int unsigned B_RX_RING_OVF = 4;
  localparam int unsigned B_UNDER_LINK  = 5;
  localparam int unsigned B_RX_FIFO_OVF = 6;
  localparam int unsigned B_LEN_CHG     = 13;
  localparam int unsigned B_TIMEOUT     = 14;
  localparam int unsigned B_BUS_ERR     = 15;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_TCMP = 2'd2,
    SEL_TCNT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wr_mask;
    logic rd_stat;
    logic wr_tcmp;
    logic wr_tcnt;
  } bus_strb_t;

endpackage

// File: rtl/irq_bus_dec.sv
module irq_bus_dec
  import net_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output reg_sel_e          sel_o,
  output logic              hit_o,
  output bus_strb_t         strb_o
);

  logic upper_zero;

  generate
    if (ADDR_W > 2) begin : g_wide
      assign upper_zero = ~|addr_i[ADDR_W-1:2];
    end else begin : g_narrow
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign sel_o = reg_sel_e'(addr_i[1:0]);
  assign hit_o = upper_zero;

  always_comb begin
    strb_o = '0;
    if (upper_zero) begin
      strb_o.wr_mask = wr_i && (sel_o == SEL_MASK);
      strb_o.wr_tcmp = wr_i && (sel_o == SEL_TCMP);
      strb_o.wr_tcnt = wr_i && (sel_o == SEL_TCNT);
      strb_o.rd_stat = rd_i && (sel_o == SEL_STAT);
      // write to status address decodes to nothing
    end
  end

  a_r7_no_stat_wr_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i) |-> !strb_o.rd_stat);
  a_r2_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({strb_o.wr_mask, strb_o.wr_tcmp, strb_o.wr_tcnt}));

endmodule

// File: rtl/irq_tick_timer.sv
module irq_tick_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_wr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q, cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_wr_i ? '0 : cnt_q + 1'b1;
      if (cmp_wr_i) cmp_q <= wdata_i;
    end
  end

  // zero threshold disables the match
  assign hit_o = (cmp_q != '0) && (cnt_q == cmp_q);
  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_o == '0));
  a_r9_free_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_i |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));
  a_r10_threshold_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_wr_i |=> $stable(cmp_o));

endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch
  import net_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] set_i,
  input  logic             clr_i,
  output logic [IRQ_W-1:0] stat_o,
  output logic [IRQ_W-1:0] stat_nxt_o
);

  logic [IRQ_W-1:0] stat_q;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    if (IRQ_IMPL[i]) begin : g_flop
      // new event wins over the clear
      assign stat_nxt_o[i] = set_i[i] | (stat_q[i] & ~clr_i);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q[i] <= 1'b0;
        else         stat_q[i] <= stat_nxt_o[i];
      end
    end else begin : g_rsvd
      assign stat_nxt_o[i] = 1'b0;
      assign stat_q[i]     = 1'b0;
    end
  end

  assign stat_o = stat_q;

  a_r3_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_o & $past(set_i & IRQ_IMPL)) == $past(set_i & IRQ_IMPL)));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> (stat_o == '0));
  a_r6_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i != '0) |=> (stat_o == $past(set_i & IRQ_IMPL)));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && set_i == '0) |=> $stable(stat_o));

endmodule

// File: rtl/net_irq_ctrl.sv
module net_irq_ctrl
  import net_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              ev_bus_err_i,
  input  logic              ev_len_chg_i,
  input  logic              ev_rx_fifo_ovf_i,
  input  logic              ev_link_chg_i,
  input  logic              rx_ptr_wr_i,
  input  logic              rx_empty_i,
  input  logic              ev_rx_ring_ovf_i,
  input  logic              ev_tx_err_i,
  input  logic              ev_tx_ok_i,
  input  logic              ev_rx_err_i,
  input  logic              ev_rx_ok_i,
  output logic              irq_no
);

  reg_sel_e         sel;
  logic             addr_hit;
  bus_strb_t        strb;
  logic [CNT_W-1:0] tmr_cnt, tmr_cmp;
  logic             tmr_hit;
  logic [IRQ_W-1:0] ev_vec, stat_q, stat_nxt;
  logic [IRQ_W-1:0] mask_q, mask_nxt;
  logic             irq_n_q;

  irq_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .sel_o  (sel),
    .hit_o  (addr_hit),
    .strb_o (strb)
  );

  irq_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmp_wr_i (strb.wr_tcmp),
    .cnt_wr_i (strb.wr_tcnt),
    .wdata_i  (wdata_i[CNT_W-1:0]),
    .cnt_o    (tmr_cnt),
    .cmp_o    (tmr_cmp),
    .hit_o    (tmr_hit)
  );

  always_comb begin
    ev_vec                = '0;
    ev_vec[B_BUS_ERR]     = ev_bus_err_i;
    ev_vec[B_TIMEOUT]     = tmr_hit;
    ev_vec[B_LEN_CHG]     = ev_len_chg_i;
    ev_vec[B_RX_FIFO_OVF] = ev_rx_fifo_ovf_i;
    ev_vec[B_UNDER_LINK]  = ev_link_chg_i | (rx_ptr_wr_i & rx_empty_i);
    ev_vec[B_RX_RING_OVF] = ev_rx_ring_ovf_i;
    ev_vec[B_TX_ERR]      = ev_tx_err_i;
    ev_vec[B_TX_OK]       = ev_tx_ok_i;
    ev_vec[B_RX_ERR]      = ev_rx_err_i;
    ev_vec[B_RX_OK]       = ev_rx_ok_i;
  end

  irq_status_latch u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (ev_vec),
    .clr_i      (strb.rd_stat),
    .stat_o     (stat_q),
    .stat_nxt_o (stat_nxt)
  );

  assign mask_nxt = strb.wr_mask ? (wdata_i & IRQ_IMPL) : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      mask_q  <= mask_nxt;
      // built from next state so the line tracks the registers without lag
      irq_n_q <= ~|(stat_nxt & mask_nxt);
    end
  end

  assign irq_no = irq_n_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i && addr_hit) begin
      unique case (sel)
        SEL_MASK: rdata_o = mask_q;
        SEL_STAT: rdata_o = stat_q;
        SEL_TCMP: rdata_o = IRQ_W'(tmr_cmp);
        SEL_TCNT: rdata_o = IRQ_W'(tmr_cnt);
        default:  rdata_o = '0;
      endcase
    end
  end

  a_r4_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == !(|(stat_q & mask_q)));
  a_r2_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.wr_mask |=> (mask_q == ($past(wdata_i) & IRQ_IMPL)));
  a_r2_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb.wr_mask |=> $stable(mask_q));
  a_r10_timeout_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_cmp == '0) |-> !ev_vec[B_TIMEOUT]);

endmodule

// File: tb/net_irq_ctrl_test.sv
module net_irq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [15:0] IMPL = 16'hE07F;
  // {mask, events}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0000, 16'h0001},
    {16'hE07F, 16'h8000},
    {16'h0004, 16'h0006},
    {16'h2000, 16'h0018},
    {16'h0040, 16'h0040},
    {16'h0020, 16'h2020},
    {16'hFFFF, 16'hA07F},
    {16'h0002, 16'h0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        e_bus, e_len, e_fifo, e_link, e_ring, e_txe, e_txok, e_rxe, e_rxok;
  logic        ptr_wr = 1'b0, rx_emp = 1'b0;
  logic        irq_n;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  net_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata),
    .ev_bus_err_i(e_bus), .ev_len_chg_i(e_len), .ev_rx_fifo_ovf_i(e_fifo),
    .ev_link_chg_i(e_link), .rx_ptr_wr_i(ptr_wr), .rx_empty_i(rx_emp),
    .ev_rx_ring_ovf_i(e_ring), .ev_tx_err_i(e_txe), .ev_tx_ok_i(e_txok),
    .ev_rx_err_i(e_rxe), .ev_rx_ok_i(e_rxok), .irq_no(irq_n)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic set_ev(input logic [15:0] ev);
    e_bus = ev[15]; e_len = ev[13]; e_fifo = ev[6]; e_link = ev[5];
    e_ring = ev[4]; e_txe = ev[3]; e_txok = ev[2]; e_rxe = ev[1]; e_rxok = ev[0];
  endtask

  task automatic pulse(input logic [15:0] ev);
    @(negedge clk); set_ev(ev);
    @(negedge clk); set_ev('0);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    set_ev('0);
    repeat (3) @(negedge clk);
    check("R1 irq at reset", {15'd0, irq_n}, 16'h1);
    rst_n = 1'b1;
    bus_rd(2'd0, d); check("R1 mask after reset", d, 16'h0000);
    bus_rd(2'd1, d); check("R1 status after reset", d, 16'h0000);
    bus_rd(2'd3, d); check("R1 counter restarted by reset", {15'd0, d < 16'd16}, 16'h1);

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] m, ev;
      m  = VEC[i][31:16];
      ev = VEC[i][15:0];
      bus_wr(2'd0, m);
      bus_rd(2'd0, d); check($sformatf("R2 mask readback v%0d", i), d, m & IMPL);
      pulse(ev);
      check($sformatf("R4 irq after events v%0d", i), {15'd0, irq_n}, {15'd0, ~|(ev & m)});
      bus_rd(2'd1, d); check($sformatf("R3 status v%0d", i), d, ev);
      check($sformatf("R5 irq after read v%0d", i), {15'd0, irq_n}, 16'h1);
      bus_rd(2'd1, d); check($sformatf("R5 cleared v%0d", i), d, 16'h0000);
    end

    // R6: event in the same cycle as a status read
    bus_wr(2'd0, 16'h0001);
    pulse(16'h0008);
    @(negedge clk); addr = 2'd1; rd = 1'b1; set_ev(16'h0001);
    #1 check("R6 read value before clear", rdata, 16'h0008);
    @(negedge clk); rd = 1'b0; set_ev('0);
    check("R6 irq stays low", {15'd0, irq_n}, 16'h0);
    bus_rd(2'd1, d); check("R6 event kept", d, 16'h0001);

    // R7: writes to status ignored
    pulse(16'h0004);
    bus_wr(2'd1, 16'hFFFF);
    bus_wr(2'd1, 16'h0000);
    bus_rd(2'd1, d); check("R7 status unchanged by writes", d, 16'h0004);

    // R8: pointer write sets bit 5 only when empty
    bus_wr(2'd0, 16'h0020);
    @(negedge clk); ptr_wr = 1'b1; rx_emp = 1'b0;
    @(negedge clk); ptr_wr = 1'b0;
    check("R8 no irq when not empty", {15'd0, irq_n}, 16'h1);
    bus_rd(2'd1, d); check("R8 no bit when not empty", d, 16'h0000);
    @(negedge clk); ptr_wr = 1'b1; rx_emp = 1'b1;
    @(negedge clk); ptr_wr = 1'b0; rx_emp = 1'b0;
    check("R8 irq when empty", {15'd0, irq_n}, 16'h0);
    bus_rd(2'd1, d); check("R8 bit 5 when empty", d, 16'h0020);

    // R11: late mask enable
    bus_wr(2'd0, 16'h0000);
    pulse(16'h0002);
    check("R11 masked pending no irq", {15'd0, irq_n}, 16'h1);
    bus_wr(2'd0, 16'h0002);
    check("R11 irq after mask enable", {15'd0, irq_n}, 16'h0);
    bus_rd(2'd1, d); check("R11 status", d, 16'h0002);

    // R9: counter restart and free run
    bus_wr(2'd3, 16'h1234);
    bus_rd(2'd3, d); check("R9 counter one after restart", d, 16'd1);
    bus_rd(2'd3, d); check("R9 counter free running", d, 16'd3);

    // R10: timeout with threshold 20
    bus_wr(2'd0, 16'h4000);
    bus_wr(2'd3, 16'h0000);
    bus_wr(2'd2, 16'd20);
    bus_rd(2'd2, d); check("R9 threshold readback", d, 16'd20);
    bus_rd(2'd1, d); check("R10 no timeout before match", d, 16'h0000);
    repeat (30) @(negedge clk);
    check("R10 irq on timeout", {15'd0, irq_n}, 16'h0);
    bus_rd(2'd1, d); check("R10 timeout bit", d, 16'h4000);

    // R10: zero threshold disables
    bus_wr(2'd2, 16'd0);
    bus_rd(2'd1, d);
    bus_wr(2'd3, 16'h0000);
    repeat (5) @(negedge clk);
    bus_rd(2'd1, d); check("R10 zero threshold no timeout", d, 16'h0000);
    check("R10 zero threshold irq high", {15'd0, irq_n}, 16'h1);

    // R1: reset in mid run
    bus_wr(2'd0, 16'hFFFF);
    pulse(16'h8001);
    check("R1 irq before reset", {15'd0, irq_n}, 16'h0);
    @(negedge clk); rst_n = 1'b0;
    #1 check("R1 irq released by reset", {15'd0, irq_n}, 16'h1);
    @(negedge clk); rst_n = 1'b1;
    bus_rd(2'd0, d); check("R1 mask cleared", d, 16'h0000);
    bus_rd(2'd1, d); check("R1 status cleared", d, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule